// File: doc/BRIEF.md
# FFT Result Frame Decimator and Index Tagger

This block sits between the result port of a streaming transform engine and two outbound FIFO write ports that feed a host. Each result sample arrives as a signed real part, a signed imaginary part and its bin index, qualified by a valid strobe. The block forwards only every second complete frame. A frame begins when a valid sample carries bin 0 and ends at bin `FRAME_LEN-1`. Samples that arrive outside a frame are discarded.

Each forwarded sample becomes two words. One carries the real part and the other carries the imaginary part. Both words repeat the same bin index in their upper half, so the host can confirm that the two channels have not slipped against each other.

Both channels must accept a sample in the same cycle. If either one cannot take it, the sample is lost on both channels and a sticky overflow flag is raised. The flag holds until the host pulses a clear. Every word also carries a frame error bit. This bit tells the host that the frame was started while the overflow flag was set, or that the frame has already lost a sample. The host can then drop the whole frame instead of trying to resynchronise.

Top module: `fft_frame_packer`

## Requirements
- R1: After reset, both output valids are low, the overflow flag is 0, and the first complete frame that arrives is forwarded.
- R2: No word is offered on either channel in a cycle where `in_valid_i` is low.
- R3: A frame starts at a valid sample with index 0. Frames are forwarded and dropped alternately, and the first frame after reset is forwarded. Every sample of a forwarded frame is offered while both readies are high, and no sample of a dropped frame is ever offered.
- R4: A channel A word has the bin index in bits 31:16 and the real part in bits 15:0.
- R5: A channel B word has the bin index in bits 31:16 and the imaginary part in bits 15:0.
- R6: `a_valid_o` and `b_valid_o` are equal in every cycle, and offered words on the two channels always carry the same index.
- R7: If a sample of a forwarded frame arrives while `a_ready_i` or `b_ready_i` is low, it is offered on neither channel and `ovf_o` is 1 from the next cycle. Readiness has no effect on the flag during dropped frames or outside frames.
- R8: `ovf_o` stays 1 until `ovf_clr_i` is pulsed, and reads 0 on the cycle after the pulse. If a new drop happens in the same cycle as the clear, the flag stays set.
- R9: `err_o` is 1 on every word of a forwarded frame that began while `ovf_o` was 1, and on every word that follows a drop within the same frame. On all other offered words it is 0.
- R10: Valid samples seen before the first index-0 sample after reset, or after bin `FRAME_LEN-1` and before the next index 0, are never offered and never raise the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Result sample strobe from the transform engine |
| in_idx_i | input | 16 | Bin index of the sample |
| in_re_i | input | 16 | Real part, signed |
| in_im_i | input | 16 | Imaginary part, signed |
| a_valid_o | output | 1 | Channel A word offered |
| a_ready_i | input | 1 | Channel A FIFO can accept a word |
| a_data_o | output | 32 | Index and real part |
| b_valid_o | output | 1 | Channel B word offered |
| b_ready_i | input | 1 | Channel B FIFO can accept a word |
| b_data_o | output | 32 | Index and imaginary part |
| err_o | output | 1 | Frame error bit that goes with the offered words |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Pulse that clears the overflow flag |

## Verification
The outbound words, their valids and `err_o` follow from the inputs of the same cycle with no register in between. The bench therefore drives every sample at the falling edge and samples these outputs one nanosecond later, before the next rising edge. `ovf_o` is registered, so it is checked one nanosecond after the rising edge that captures the drop or the clear. The bench models the frame phase, the in-frame state and the error state itself, and updates that model at the same edge where the design updates its own registers.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  typedef enum logic {LANE_RE = 1'b0, LANE_IM = 1'b1} lane_e;
endpackage

// File: rtl/fpk_decim.sv
// Frame boundary tracking and alternate-frame selection.
module fpk_decim #(
  parameter int IDX_W     = 16,
  parameter int FRAME_LEN = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             start_o,
  output logic             fwd_o
);
  localparam logic [IDX_W-1:0] IdxLast = IDX_W'(FRAME_LEN - 1);

  logic phase_q;   // 1: next frame is forwarded
  logic in_fwd_q;  // currently inside a forwarded frame
  logic last;

  assign start_o = valid_i && (idx_i == '0);
  assign last    = valid_i && (idx_i == IdxLast);
  assign fwd_o   = start_o ? phase_q : in_fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b1;
      in_fwd_q <= 1'b0;
    end else if (start_o) begin
      phase_q  <= ~phase_q;
      in_fwd_q <= phase_q && !last;
    end else if (last) begin
      in_fwd_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fpk_status.sv
// Sticky overflow and per-frame error tracking.
module fpk_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic space_i,
  input  logic start_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic err_o
);
  logic ovf_q, err_q, drop;

  assign drop  = take_i && !space_i;
  assign ovf_o = ovf_q;
  assign err_o = take_i && (start_i ? ovf_q : err_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (drop)       ovf_q <= 1'b1;
      else if (clr_i) ovf_q <= 1'b0;
      if (start_i && take_i) err_q <= ovf_q || drop;
      else if (drop)         err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fpk_lane.sv
// Packs index with one result component.
module fpk_lane #(
  parameter int IDX_W = 16,
  parameter int DAT_W = 16
) (
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DAT_W-1:0]       dat_i,
  output logic [IDX_W+DAT_W-1:0] word_o
);
  assign word_o = {idx_i, dat_i};
endmodule

// File: rtl/fft_frame_packer.sv
module fft_frame_packer #(
  parameter int IDX_W     = 16,
  parameter int DAT_W     = 16,
  parameter int FRAME_LEN = 4096,
  localparam int WORD_W   = IDX_W + DAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  input  logic [DAT_W-1:0]  in_re_i,
  input  logic [DAT_W-1:0]  in_im_i,
  output logic              a_valid_o,
  input  logic              a_ready_i,
  output logic [WORD_W-1:0] a_data_o,
  output logic              b_valid_o,
  input  logic              b_ready_i,
  output logic [WORD_W-1:0] b_data_o,
  output logic              err_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  import fpk_pkg::*;

  logic start, fwd, take, space, emit;
  logic [DAT_W-1:0]  comp [2];
  logic [WORD_W-1:0] word [2];

  fpk_decim #(.IDX_W(IDX_W), .FRAME_LEN(FRAME_LEN)) u_decim (
    .clk_i, .rst_ni, .valid_i(in_valid_i), .idx_i(in_idx_i),
    .start_o(start), .fwd_o(fwd)
  );

  assign take  = in_valid_i && fwd;
  assign space = a_ready_i && b_ready_i;
  assign emit  = take && space;

  fpk_status u_status (
    .clk_i, .rst_ni, .take_i(take), .space_i(space), .start_i(start),
    .clr_i(ovf_clr_i), .ovf_o(ovf_o), .err_o(err_o)
  );

  assign comp[LANE_RE] = in_re_i;
  assign comp[LANE_IM] = in_im_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    fpk_lane #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_lane (
      .idx_i(in_idx_i), .dat_i(comp[g]), .word_o(word[g])
    );
  end

  assign a_valid_o = emit;
  assign b_valid_o = emit;
  assign a_data_o  = word[LANE_RE];
  assign b_data_o  = word[LANE_IM];
endmodule

// File: rtl/fpk_checker.sv
module fpk_checker #(
  parameter int IDX_W  = 16,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [IDX_W-1:0]  in_idx_i,
  input logic              a_valid_o,
  input logic              a_ready_i,
  input logic [WORD_W-1:0] a_data_o,
  input logic              b_valid_o,
  input logic              b_ready_i,
  input logic [WORD_W-1:0] b_data_o,
  input logic              ovf_o,
  input logic              ovf_clr_i
);
  // R6
  valid_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_o == b_valid_o);

  // R6
  idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_o |-> (a_data_o[WORD_W-1:WORD_W-IDX_W] == b_data_o[WORD_W-1:WORD_W-IDX_W]));

  // R4
  idx_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_o |-> (a_data_o[WORD_W-1:WORD_W-IDX_W] == in_idx_i));

  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_o |-> (in_valid_i && a_ready_i && b_ready_i));

  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(in_valid_i && !(a_ready_i && b_ready_i)));

  // R8
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind fft_frame_packer fpk_checker #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_idx_i, .a_valid_o, .a_ready_i, .a_data_o,
  .b_valid_o, .b_ready_i, .b_data_o, .ovf_o, .ovf_clr_i
);

// File: tb/fft_frame_packer_bench.sv
`timescale 1ns/1ps
module fft_frame_packer_bench;
  localparam int FL = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, a_ready_i = 1'b1, b_ready_i = 1'b1, ovf_clr_i = 1'b0;
  logic [15:0] in_idx_i = '0, in_re_i = '0, in_im_i = '0;
  logic a_valid_o, b_valid_o, err_o, ovf_o;
  logic [31:0] a_data_o, b_data_o;

  int n_chk = 0, n_bad = 0;
  bit m_phase = 1'b1, m_infwd = 1'b0, m_ovf = 1'b0, m_err = 1'b0;

  always #5 clk_i = ~clk_i;

  fft_frame_packer #(.FRAME_LEN(FL)) u_fft_frame_packer (
    .clk_i, .rst_ni, .in_valid_i, .in_idx_i, .in_re_i, .in_im_i,
    .a_valid_o, .a_ready_i, .a_data_o, .b_valid_o, .b_ready_i, .b_data_o,
    .err_o, .ovf_o, .ovf_clr_i
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One input cycle; checks outputs against the bench model.
  task automatic drive(input bit v, input int idx, input int re, input int im,
                       input bit ar, input bit br, input bit clr, output bit emitted);
    bit start, last, fwd, take, emit, xerr, drop, old_phase;
    @(negedge clk_i);
    in_valid_i = v; in_idx_i = 16'(idx); in_re_i = 16'(re); in_im_i = 16'(im);
    a_ready_i = ar; b_ready_i = br; ovf_clr_i = clr;
    #1;
    start = v && (idx == 0);
    last  = v && (idx == FL - 1);
    fwd   = start ? m_phase : m_infwd;
    take  = v && fwd;
    emit  = take && ar && br;
    xerr  = start ? m_ovf : m_err;
    chk(a_valid_o == b_valid_o, "R6", "valid pair", a_valid_o, b_valid_o);
    chk(a_valid_o == emit, "R3", "a_valid", a_valid_o, emit);
    if (emit) begin
      chk(a_data_o == {16'(idx), 16'(re)}, "R4", "a_data", a_data_o, {16'(idx), 16'(re)});
      chk(b_data_o == {16'(idx), 16'(im)}, "R5", "b_data", b_data_o, {16'(idx), 16'(im)});
      chk(err_o == xerr, "R9", "err", err_o, xerr);
    end
    emitted = emit;
    drop = take && !(ar && br);
    old_phase = m_phase;
    if (start) begin
      m_phase = ~m_phase;
      m_infwd = old_phase && !last;
    end else if (last) m_infwd = 1'b0;
    if (start && take) m_err = m_ovf || drop;
    else if (drop) m_err = 1'b1;
    if (drop) m_ovf = 1'b1;
    else if (clr) m_ovf = 1'b0;
    @(posedge clk_i); #1;
    chk(ovf_o == m_ovf, "R8", "ovf", ovf_o, m_ovf);
  endtask

  // Sends one frame with a peak at bin 4; stall_idx < 0 means no stall.
  task automatic send_frame(input int stall_idx, input bit a_rdy, output int cnt);
    bit e;
    cnt = 0;
    for (int i = 0; i < FL; i++) begin
      drive(1'b1, i, (i == 4) ? 1000 : i, (i == 4) ? -500 : -i,
            a_rdy, (i != stall_idx), 1'b0, e);
      cnt += int'(e);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(a_valid_o == 1'b0 && b_valid_o == 1'b0, "R1", "valid in reset", a_valid_o, 0);
    chk(ovf_o == 1'b0, "R1", "ovf in reset", ovf_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(ovf_o == 1'b0, "R1", "ovf after reset", ovf_o, 0);
  endtask

  task automatic t_idle;
    bit e;
    drive(1'b0, 0, 7, 7, 1'b1, 1'b1, 1'b0, e);
    chk(e == 1'b0 && a_valid_o == 1'b0, "R2", "no word without valid", a_valid_o, 0);
    // R10: stray samples before first frame start, with backpressure
    for (int i = 5; i < 8; i++) drive(1'b1, i, 3, 3, 1'b0, 1'b1, 1'b0, e);
    chk(ovf_o == 1'b0, "R10", "no ovf outside frame", ovf_o, 0);
  endtask

  task automatic t_decim;
    int c;
    bit e;
    for (int f = 0; f < 4; f++) begin
      send_frame(-1, 1'b1, c);
      chk(c == ((f % 2 == 0) ? FL : 0), "R3", "words in frame", c, (f % 2 == 0) ? FL : 0);
    end
    drive(1'b1, 3, 9, 9, 1'b1, 1'b1, 1'b0, e);
    chk(e == 1'b0, "R10", "sample after last bin", e, 0);
  endtask

  task automatic t_overflow;
    int c;
    send_frame(6, 1'b1, c);
    chk(c == FL - 1, "R7", "words with one stall", c, FL - 1);
    chk(ovf_o == 1'b1, "R7", "ovf set", ovf_o, 1);
    send_frame(-1, 1'b0, c);
    chk(c == 0, "R7", "dropped frame under backpressure", c, 0);
    send_frame(-1, 1'b1, c);
    chk(c == FL, "R9", "errored frame words", c, FL);
  endtask

  task automatic t_clear;
    int c;
    bit e;
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b0, e);
    chk(ovf_o == 1'b1, "R8", "ovf holds", ovf_o, 1);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b1, e);
    chk(ovf_o == 1'b0, "R8", "ovf cleared", ovf_o, 0);
    send_frame(-1, 1'b1, c);
    send_frame(-1, 1'b1, c);
    chk(c == FL, "R9", "clean frame words", c, FL);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_idle();
        t_decim();
        t_overflow();
        t_clear();
      end
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule